// File: doc/BRIEF.md
# Compare-Capture General Purpose Timer

A register-mapped timer built around an up-counter whose width is a parameter (32 bits by default). Software programs it through a simple word-addressed bus. Each clock the bus carries an address, a write strobe and write data, and the read data comes back registered. The counter advances on count ticks. A source-select field picks where those ticks come from, out of five single-cycle pulse inputs or none. The selected ticks then pass through a 12-bit divider. The crystal-reference source first passes through a second, 4-bit divider. That source is only used when its reference-enable bit is set.

Three compare channels watch the counter. Each one raises a status flag when the counter takes its compare value, and each drives an output pin in a programmable way. Two capture channels synchronise an external pin and detect the selected edges on it. On such an edge they copy the counter into a capture register and raise a flag. Status flags are cleared by writing ones to them. The interrupt line is the registered OR of the flags whose enables are set. A soft-reset bit returns the whole register file to its defaults and then drops by itself.

Word addresses: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare 1 to 3, 7 and 8 capture 1 and 2, 9 counter. Control fields:
- bit 0: run.
- bit 1: clear-on-start.
- bits 2 to 5: stored only.
- bits 8:6: source select.
- bit 9: free-run.
- bit 10: reference enable.
- bit 15: soft reset.
- bits 17:16 and 19:18: capture modes.
- bits 22:20, 25:23 and 28:26: pin modes.
- bits 31:29: force strobes.

Top module: `cc_timer`

## Requirements
- R1: After `rst`, every register reads 0 except the three compare registers, which read all ones (the counter width). `irq` and all `cmp_pin` bits are 0.
- R2: A read of word address A returns that register in `bus_rdata` on the clock after the address is presented. Addresses 10 to 15 read 0. The prescaler register keeps only bits 15:0 of a write.
- R3: With run set and source 1 to 4 selected, the counter advances once per N+1 pulses on `src_pulse[source-1]`, where N is prescaler bits 11:0. With run clear, or with source 0, the counter holds.
- R4: Source 5 counts `src_pulse[4]` only while reference enable (bit 10) is set. It divides the pulses by (bits 15:12)+1 and then by (bits 11:0)+1.
- R5: In free-run mode (bit 9 = 1) the counter wraps from all ones to 0 and sets status bit 5.
- R6: In restart mode (bit 9 = 0) the tick after the counter equals compare 1 loads 0.
- R7: Status bit i-1 (i = 1..3) is set on the tick that makes the counter equal to compare i.
- R8: Writing a 1 to a status bit clears it, and writing 0 leaves it. An event in the same cycle as the clear wins.
- R9: `irq` is high one clock after any status bit with its matching interrupt-enable bit (same position) is set.
- R10: With clear-on-start (bit 1) set, a write that takes run from 0 to 1 zeroes the counter and both dividers. Dropping run alone keeps the count.
- R11: Capture mode 01 reacts to rising edges, 10 to falling edges and 11 to both. On a selected edge of the synchronised `cap_pin[j]`, the current count is stored in capture j+1 and status bit 3+j is set.
- R12: On a match, pin mode 001 toggles the pin, 010 clears it, 011 sets it and 000 leaves it. Modes 1xx hold the pin high with a one-clock low pulse per match. Writing 1 to a force bit (29+i for channel i) applies the action under the newly written mode without setting a flag, and force bits read 0.
- R13: Writing control bit 15 reads back as 1 for one clock. The next clock returns all registers, pins and the counter to the R1 state, and the bit reads 0.
- R14: Writes to the capture and counter addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_pulse | input | 5 | Tick pulses for sources 1 to 5 |
| cap_pin | input | 2 | Capture inputs |
| cmp_pin | output | 3 | Compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `src_pulse` is synchronous to `clk` and lasts one clock per tick. They also assume that the counter changes only through ticks, start-clearing writes or soft reset. The hold and rollover checks therefore exclude cycles with a bus write. The bench applies every bus access and pulse at the falling edge. It keeps all source pulses low while it reads results, so every expected count is exact. It holds capture inputs steady for several clocks around each edge, so that the synchroniser sees one clean transition.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int N_CMP   = 3;
  localparam int N_CAP   = 2;
  localparam int N_SRC   = 5;
  localparam int PSC_W   = 12;
  localparam int XPSC_W  = 4;
  localparam int OMODE_W = 3;
  localparam int N_FLAGS = N_CMP + N_CAP + 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PSC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP0 = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;

  localparam int B_RUN   = 0;
  localparam int B_CLRST = 1;
  localparam int B_SRC   = 6;
  localparam int B_FREE  = 9;
  localparam int B_REFEN = 10;
  localparam int B_SWR   = 15;
  localparam int B_CAPM  = 16;
  localparam int B_OMODE = 20;
  localparam int B_FORCE = 29;

  localparam int S_CMP  = 0;
  localparam int S_CAP  = N_CMP;
  localparam int S_ROLL = N_CMP + N_CAP;

  localparam logic [2:0] SRC_XTAL = 3'd5;
endpackage

// File: rtl/cc_divider.sv
module cc_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] div,
  output logic         tick_out
);
  logic [W-1:0] acc_q;

  assign tick_out = tick_in && (acc_q == div);

  always_ff @(posedge clk) begin
    if (rst || clr)   acc_q <= '0;
    else if (tick_in) acc_q <= (acc_q == div) ? '0 : acc_q + 1'b1;
  end
endmodule

// File: rtl/cc_capture.sv
module cc_capture #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !prev_q;
  assign fall = !sync_q[STAGES-1] && prev_q;
  assign hit  = (mode[0] && rise) || (mode[1] && fall);
endmodule

// File: rtl/cc_outpin.sv
module cc_outpin (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       fire,
  output logic       pin
);
  always_ff @(posedge clk) begin
    if (rst)          pin <= 1'b0;
    else if (mode[2]) pin <= !fire;
    else if (fire) begin
      case (mode[1:0])
        2'b01:   pin <= !pin;
        2'b10:   pin <= 1'b0;
        2'b11:   pin <= 1'b1;
        default: pin <= pin;
      endcase
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_pulse,
  input  logic [N_CAP-1:0]  cap_pin,
  output logic [N_CMP-1:0]  cmp_pin,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_ONES = '1;
  localparam int OM_W = N_CMP * OMODE_W;

  logic [REG_W-1:0]        ctrl_q;
  logic [PSC_W+XPSC_W-1:0] psc_q;
  logic [N_FLAGS-1:0]      sr_q, ier_q, flag_set, flag_clr;
  logic [CNT_W-1:0]        cmp_q [N_CMP];
  logic [CNT_W-1:0]        cap_q [N_CAP];
  logic [CNT_W-1:0]        cnt_q, cnt_nxt;
  logic [N_CMP-1:0]        force_fire;
  logic [N_CAP-1:0]        cap_hit;
  logic [OM_W-1:0]         omode;
  logic [2:0]              src_sel;
  logic                    srst, wr_ctrl, en_rise, run, reload;
  logic                    tick_x_in, tick_x, sel_tick, tick;
  logic                    irq_q;
  logic [REG_W-1:0]        rd_q, rd_mux;

  assign srst    = rst | ctrl_q[B_SWR];
  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign run     = ctrl_q[B_RUN];
  assign en_rise = wr_ctrl && bus_wdata[B_RUN] && bus_wdata[B_CLRST] && !run;
  assign src_sel = ctrl_q[B_SRC +: 3];

  // tick selection and the two cascaded dividers
  assign tick_x_in = run && (src_sel == SRC_XTAL) && ctrl_q[B_REFEN] && src_pulse[N_SRC-1];

  always_comb begin
    case (src_sel)
      3'd1:     sel_tick = src_pulse[0];
      3'd2:     sel_tick = src_pulse[1];
      3'd3:     sel_tick = src_pulse[2];
      3'd4:     sel_tick = src_pulse[3];
      SRC_XTAL: sel_tick = tick_x;
      default:  sel_tick = 1'b0;
    endcase
  end

  cc_divider #(.W(XPSC_W)) u_xdiv (
    .clk(clk), .rst(srst), .clr(en_rise), .tick_in(tick_x_in),
    .div(psc_q[PSC_W +: XPSC_W]), .tick_out(tick_x)
  );

  cc_divider #(.W(PSC_W)) u_mdiv (
    .clk(clk), .rst(srst), .clr(en_rise), .tick_in(run && sel_tick),
    .div(psc_q[PSC_W-1:0]), .tick_out(tick)
  );

  // counter next value and events
  assign reload  = !ctrl_q[B_FREE] && (cnt_q == cmp_q[0]);
  assign cnt_nxt = reload ? '0 : cnt_q + 1'b1;

  assign flag_set[S_ROLL] = tick && !reload && (cnt_q == CNT_ONES);
  assign flag_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[N_FLAGS-1:0] : '0;

  assign omode      = wr_ctrl ? bus_wdata[B_OMODE +: OM_W] : ctrl_q[B_OMODE +: OM_W];
  assign force_fire = wr_ctrl ? bus_wdata[B_FORCE +: N_CMP] : '0;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign flag_set[S_CMP+i] = tick && (cnt_nxt == cmp_q[i]);

    always_ff @(posedge clk) begin
      if (srst) cmp_q[i] <= '1;
      else if (bus_we && bus_addr == A_CMP0 + ADDR_W'(i)) cmp_q[i] <= bus_wdata[CNT_W-1:0];
    end

    cc_outpin u_pin (
      .clk(clk), .rst(srst), .mode(omode[i*OMODE_W +: OMODE_W]),
      .fire(flag_set[S_CMP+i] | force_fire[i]), .pin(cmp_pin[i])
    );
  end

  for (genvar j = 0; j < N_CAP; j++) begin : g_cap
    cc_capture #(.STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst(srst), .pin(cap_pin[j]),
      .mode(ctrl_q[B_CAPM + 2*j +: 2]), .hit(cap_hit[j])
    );

    assign flag_set[S_CAP+j] = cap_hit[j];

    always_ff @(posedge clk) begin
      if (srst)            cap_q[j] <= '0;
      else if (cap_hit[j]) cap_q[j] <= cnt_q;
    end
  end

  // register file and counter
  always_ff @(posedge clk) begin
    if (srst) begin
      ctrl_q <= '0;
      psc_q  <= '0;
      sr_q   <= '0;
      ier_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= {{(REG_W-B_FORCE){1'b0}}, bus_wdata[B_FORCE-1:0]};
      if (bus_we && bus_addr == A_PSC) psc_q <= bus_wdata[PSC_W+XPSC_W-1:0];
      if (bus_we && bus_addr == A_IEN) ier_q <= bus_wdata[N_FLAGS-1:0];
      sr_q <= (sr_q & ~flag_clr) | flag_set;
      if (en_rise)   cnt_q <= '0;
      else if (tick) cnt_q <= cnt_nxt;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:        rd_mux = ctrl_q;
      A_PSC:         rd_mux = REG_W'(psc_q);
      A_STAT:        rd_mux = REG_W'(sr_q);
      A_IEN:         rd_mux = REG_W'(ier_q);
      A_CMP0:        rd_mux = REG_W'(cmp_q[0]);
      A_CMP0 + 4'd1: rd_mux = REG_W'(cmp_q[1]);
      A_CMP0 + 4'd2: rd_mux = REG_W'(cmp_q[2]);
      A_CAP0:        rd_mux = REG_W'(cap_q[0]);
      A_CAP0 + 4'd1: rd_mux = REG_W'(cap_q[1]);
      A_CNT:         rd_mux = REG_W'(cnt_q);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      rd_q  <= rd_mux;
      irq_q <= |(sr_q & ier_q);
    end
  end

  assign bus_rdata = rd_q;
  assign irq       = irq_q;
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       bus_addr,
  input logic             bus_we,
  input logic [31:0]      bus_rdata,
  input logic             run,
  input logic             swr,
  input logic             free,
  input logic [CNT_W-1:0] cnt,
  input logic [5:0]       sr
);
  assert_swr_selfclear_R13: assert property (@(posedge clk) disable iff (rst)
    swr |=> (!swr && cnt == '0 && sr == '0));

  assert_force_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == 4'd0) |-> (bus_rdata[31:29] == 3'b000));

  assert_hold_when_stopped_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && !swr && !bus_we) |=> $stable(cnt));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !swr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));

  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (run && free && !swr && !bus_we && (&cnt)) |=> (cnt != '0 || sr[5]));
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .run(ctrl_q[0]), .swr(ctrl_q[15]), .free(ctrl_q[9]), .cnt(cnt_q), .sr(sr_q)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  src_pulse = '0;
  logic [1:0]  cap_pin = '0;
  logic [2:0]  cmp_pin;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  logic        rd_issue = 1'b0;
  logic        rd_issue_d = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  cc_timer #(.CNT_W(8)) u_cc_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_pulse(src_pulse), .cap_pin(cap_pin),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares each registered read result against the scoreboard
  always @(posedge clk) rd_issue_d <= rd_issue;
  always @(negedge clk) begin
    if (rd_issue_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata, e, t);
    end
  end

  // driver tasks, entered and left at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    bus_addr = a; rd_issue = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    src_pulse = 5'b00001 << idx;
    repeat (n) @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic sreset();
    wr(4'd0, 32'h0000_8000);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state and map
    chk({31'd0, irq}, 32'd0, "R1 irq");
    chk({29'd0, cmp_pin}, 32'd0, "R1 pins");
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 psc");
    rd(4'd2, 32'h0, "R1 stat");
    rd(4'd3, 32'h0, "R1 ien");
    rd(4'd4, 32'hFF, "R1 cmp1");
    rd(4'd5, 32'hFF, "R1 cmp2");
    rd(4'd6, 32'hFF, "R1 cmp3");
    rd(4'd7, 32'h0, "R1 cap1");
    rd(4'd8, 32'h0, "R1 cap2");
    rd(4'd9, 32'h0, "R1 cnt");
    rd(4'd12, 32'h0, "R2 unused addr");
    wr(4'd1, 32'hABCD_1234);
    rd(4'd1, 32'h0000_1234, "R2 psc width");
    wr(4'd7, 32'h55); wr(4'd9, 32'h55);
    rd(4'd7, 32'h0, "R14 cap1 read-only");
    rd(4'd9, 32'h0, "R14 cnt read-only");

    // soft reset
    wr(4'd4, 32'h10);
    rd(4'd4, 32'h10, "R2 cmp1 write");
    wr(4'd0, 32'h0000_8000);
    rd(4'd0, 32'h0000_8000, "R13 bit visible");
    rd(4'd0, 32'h0, "R13 bit cleared");
    rd(4'd1, 32'h0, "R13 psc default");
    rd(4'd4, 32'hFF, "R13 cmp1 default");

    // main divider and gating
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h0000_0241);
    pulse(0, 9);
    rd(4'd9, 32'd3, "R3 divide by 3");
    wr(4'd0, 32'h0000_0201);
    pulse(0, 5);
    rd(4'd9, 32'd3, "R3 source none");
    wr(4'd0, 32'h0000_0240);
    pulse(0, 6);
    rd(4'd9, 32'd3, "R3 run clear");

    // crystal path
    sreset();
    wr(4'd1, 32'h0000_2001);
    wr(4'd0, 32'h0000_0741);
    pulse(4, 12);
    rd(4'd9, 32'd2, "R4 cascade /6");
    wr(4'd0, 32'h0000_0341);
    pulse(4, 12);
    rd(4'd9, 32'd2, "R4 ref disabled");

    // clear-on-start
    wr(4'd0, 32'h0000_0242);
    rd(4'd9, 32'd2, "R10 stop keeps count");
    wr(4'd0, 32'h0000_0243);
    rd(4'd9, 32'd0, "R10 start clears count");
    pulse(0, 1);
    wr(4'd0, 32'h0000_0242);
    wr(4'd0, 32'h0000_0243);
    pulse(0, 1);
    rd(4'd9, 32'd0, "R10 divider cleared");
    pulse(0, 1);
    rd(4'd9, 32'd1, "R10 count after clear");

    // rollover and compare flags
    sreset();
    wr(4'd0, 32'h0000_0241);
    pulse(0, 256);
    rd(4'd2, 32'h27, "R5 R7 wrap and matches");
    rd(4'd9, 32'd0, "R5 wrapped count");
    wr(4'd5, 32'h10);
    wr(4'd2, 32'h3F);
    pulse(0, 16);
    rd(4'd2, 32'h02, "R7 compare 2 only");

    // write-one-to-clear
    wr(4'd2, 32'h00);
    rd(4'd2, 32'h02, "R8 zero write keeps");
    wr(4'd2, 32'h02);
    rd(4'd2, 32'h00, "R8 one clears");
    wr(4'd4, 32'h11);
    bus_addr = 4'd2; bus_wdata = 32'h1; bus_we = 1'b1; src_pulse = 5'b00001;
    @(negedge clk);
    bus_we = 1'b0; src_pulse = '0;
    rd(4'd2, 32'h01, "R8 set wins");

    // interrupt
    chk({31'd0, irq}, 32'd0, "R9 masked");
    wr(4'd3, 32'h01);
    @(negedge clk);
    chk({31'd0, irq}, 32'd1, "R9 enabled");
    wr(4'd3, 32'h02);
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R9 other enable");

    // restart mode
    sreset();
    wr(4'd4, 32'd3);
    wr(4'd0, 32'h0000_0041);
    pulse(0, 4);
    rd(4'd9, 32'd0, "R6 reload");
    rd(4'd2, 32'h01, "R6 match flag");
    pulse(0, 2);
    rd(4'd9, 32'd2, "R6 counts again");

    // capture
    sreset();
    wr(4'd0, 32'h0009_0241);
    pulse(0, 5);
    cap_pin = 2'b01;
    repeat (5) @(negedge clk);
    rd(4'd7, 32'd5, "R11 rising capture");
    rd(4'd2, 32'h08, "R11 flag 3");
    cap_pin = 2'b11;
    repeat (5) @(negedge clk);
    rd(4'd2, 32'h08, "R11 unselected edge");
    rd(4'd8, 32'd0, "R11 cap2 untouched");
    pulse(0, 2);
    cap_pin = 2'b01;
    repeat (5) @(negedge clk);
    rd(4'd8, 32'd7, "R11 falling capture");
    rd(4'd7, 32'd5, "R11 cap1 kept");
    rd(4'd2, 32'h18, "R11 both flags");
    wr(4'd0, 32'h000B_0241);
    cap_pin = 2'b00;
    repeat (5) @(negedge clk);
    rd(4'd7, 32'd7, "R11 both-edge mode");

    // output pins
    sreset();
    wr(4'd0, 32'h1190_0241);
    wr(4'd4, 32'd2); wr(4'd5, 32'd2); wr(4'd6, 32'd2);
    chk({29'd0, cmp_pin}, 32'h4, "R12 pulse idle high");
    pulse(0, 2);
    chk({29'd0, cmp_pin}, 32'h3, "R12 match actions");
    @(negedge clk);
    chk({29'd0, cmp_pin}, 32'h7, "R12 pulse ends");
    wr(4'd2, 32'h3F);
    wr(4'd0, 32'h3190_0241);
    chk({29'd0, cmp_pin}, 32'h6, "R12 force toggle");
    rd(4'd2, 32'h0, "R12 force no flag");
    rd(4'd0, 32'h1190_0241, "R12 force reads 0");
    wr(4'd0, 32'h9190_0241);
    chk({29'd0, cmp_pin}, 32'h2, "R12 forced pulse");
    @(negedge clk);
    chk({29'd0, cmp_pin}, 32'h6, "R12 forced pulse ends");
    wr(4'd0, 32'h5110_0241);
    chk({29'd0, cmp_pin}, 32'h4, "R12 force clear");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule